// File: doc/BRIEF.md
# Branch Outcome History Table

This block keeps a set-associative record of conditional branches, keyed by instruction address, and scores how well a small saturating counter per entry would have predicted them. Each cycle the core may present one resolved branch as an address with its taken bit. The block looks the address up in the set the address selects. On a hit it reports the direction the stored counter predicted before this outcome, counts that prediction as right or wrong, and moves the counter toward the outcome. On a miss it claims a way for the branch and seeds that way's counter from the outcome that caused the fill.

Replacement does not use true LRU. Each way carries a small usage counter. Every access to a set decays the usage of all ways in the set, and the touched way is then refreshed to full. The victim is the highest-numbered way whose usage is below full, and way 0 when no way qualifies. Four saturating counters record hits, misses, right predictions and wrong predictions for performance study. The block has no influence on fetch and stores no targets.

Top module: `bhb_table`

## Requirements
- R1: After reset, resp_valid is low, all four counts read zero and every way is empty, so the first access to any address, including address 0, is a miss.
- R2: The set is the address modulo NUM_SETS. A hit needs a filled way in that set that holds the identical full address, so two addresses that share a set but differ never hit on each other's entry.
- R3: On a miss the chosen way takes the address and its counter is seeded to PRED_STATES/2 - 1 plus the taken bit. With two states the next hit predicts the outcome that filled the way. With four states the seed is 2 for taken and 1 for not taken.
- R4: One cycle after an accepted update, resp_valid is high and resp_hit gives the lookup result. On a hit resp_pred is 1 when the counter before the update was at least PRED_STATES/2. On a miss resp_pred is 0.
- R5: On a hit the counter rises by one when taken and below PRED_STATES-1, falls by one when not taken and above 0, and otherwise holds.
- R6: On every accepted access, each other way in the set whose usage is non-zero drops by one, and the hit or filled way is set to USE_STATES-1.
- R7: On a miss the victim is the highest-numbered way in the set whose usage is below USE_STATES-1. When no way qualifies, way 0 is the victim.
- R8: Each accepted update adds one to exactly one of hit_count and miss_count. A hit also adds one to right_count when resp_pred equals the taken bit, and to wrong_count otherwise. A miss changes neither right_count nor wrong_count.
- R9: An update is accepted only when en and upd_valid are both high. Otherwise the table and the counts do not change and resp_valid is low in the next cycle.
- R10: Each count saturates at 2^STAT_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; when low, updates are ignored |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Instruction address of the branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| resp_valid | output | 1 | Registered; the previous cycle's update was accepted |
| resp_hit | output | 1 | Registered lookup result for that update |
| resp_pred | output | 1 | Registered prediction before the update (0 on a miss) |
| hit_count | output | STAT_W | Saturating hit count |
| miss_count | output | STAT_W | Saturating miss count |
| right_count | output | STAT_W | Saturating count of correct predictions on hits |
| wrong_count | output | STAT_W | Saturating count of wrong predictions on hits |

## Verification
The assertions cover the properties that hold in every cycle. A response must come from an accepted update. A miss reports no prediction and leaves the scoring counts unchanged. Scoring only happens on a hit. The lookup never matches two ways. The victim's usage is below full, or the victim is way 0. Idle counts hold, and a count either steps by one or clamps. Whether the right entry was found, how the counter was seeded and moved, and which way the decaying usage counters evicted depend on earlier history. Only the bench's directed sequences show these: aliasing addresses, counter walks to both rails, a replacement sequence in a two-way, three-usage-state configuration, and a small-count instance driven past its maximum.

// File: rtl/bhb_pkg.sv
package bhb_pkg;

    // Width of an index over n items, at least one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // One saturating step of a direction counter toward the outcome.
    function automatic int dir_step(input int cur, input logic up, input int top);
        if (up)
            return (cur < top) ? cur + 1 : cur;
        else
            return (cur > 0) ? cur - 1 : cur;
    endfunction

    // Events produced by one accepted update.
    typedef struct packed {
        logic hit;
        logic miss;
        logic right;
        logic wrong;
    } bhb_evt_t;

endpackage

// File: rtl/bhb_lookup.sv
module bhb_lookup #(
    parameter int NUM_WAYS   = 1,
    parameter int USE_STATES = 2,
    parameter int ADDR_W     = 32,
    localparam int WAY_W     = bhb_pkg::idx_bits(NUM_WAYS),
    localparam int USE_W     = bhb_pkg::idx_bits(USE_STATES),
    localparam int USE_MAX   = USE_STATES - 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 look_addr,
    input  logic [NUM_WAYS-1:0]               row_vld,
    input  logic [NUM_WAYS-1:0][ADDR_W-1:0]   row_tag,
    input  logic [NUM_WAYS-1:0][USE_W-1:0]    row_use,
    output logic                              hit,
    output logic [WAY_W-1:0]                  hit_way,
    output logic [WAY_W-1:0]                  victim_way
);

    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] below;

    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_way
            assign match[g] = row_vld[g] && (row_tag[g] == look_addr);
            assign below[g] = row_use[g] < USE_W'(USE_MAX);
        end
    endgenerate

    always_comb begin
        hit        = |match;
        hit_way    = '0;
        victim_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
            if (below[w]) victim_way = WAY_W'(w);
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R2
    AST_VICTIM_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        (|below) |-> (row_use[victim_way] < USE_W'(USE_MAX))); // R7
    AST_VICTIM_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        !(|below) |-> (victim_way == '0)); // R7

endmodule

// File: rtl/bhb_satcnt.sv
module bhb_satcnt #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [STAT_W-1:0] count
);

    localparam logic [STAT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + STAT_W'(1);
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && count != TOP) |=> (count == $past(count) + STAT_W'(1))); // R8
    AST_CNT_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (count == TOP) |=> (count == TOP)); // R10

endmodule

// File: rtl/bhb_table.sv
module bhb_table
    import bhb_pkg::*;
#(
    parameter int NUM_SETS    = 64,
    parameter int NUM_WAYS    = 1,
    parameter int PRED_STATES = 2,
    parameter int USE_STATES  = 2,
    parameter int ADDR_W      = 32,
    parameter int STAT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_pred,
    output logic [STAT_W-1:0] hit_count,
    output logic [STAT_W-1:0] miss_count,
    output logic [STAT_W-1:0] right_count,
    output logic [STAT_W-1:0] wrong_count
);

    localparam int SET_W   = idx_bits(NUM_SETS);
    localparam int WAY_W   = idx_bits(NUM_WAYS);
    localparam int CTR_W   = idx_bits(PRED_STATES);
    localparam int USE_W   = idx_bits(USE_STATES);
    localparam int CTR_MAX = PRED_STATES - 1;
    localparam int HALF    = PRED_STATES / 2;
    localparam int USE_MAX = USE_STATES - 1;

    // Table storage, one flop group per set and way.
    logic              vld_q [NUM_SETS][NUM_WAYS];
    logic [ADDR_W-1:0] tag_q [NUM_SETS][NUM_WAYS];
    logic [CTR_W-1:0]  ctr_q [NUM_SETS][NUM_WAYS];
    logic [USE_W-1:0]  use_q [NUM_SETS][NUM_WAYS];

    logic                            access;
    logic [SET_W-1:0]                set_idx;
    logic [NUM_WAYS-1:0]             row_vld;
    logic [NUM_WAYS-1:0][ADDR_W-1:0] row_tag;
    logic [NUM_WAYS-1:0][USE_W-1:0]  row_use;
    logic [NUM_WAYS-1:0][CTR_W-1:0]  row_ctr;
    logic                            hit;
    logic [WAY_W-1:0]                hit_way;
    logic [WAY_W-1:0]                victim_way;
    logic [WAY_W-1:0]                tgt_way;
    logic [CTR_W-1:0]                cur_ctr;
    logic [CTR_W-1:0]                new_ctr;
    logic                            pred_dir;
    bhb_evt_t                        evt;

    assign access  = en && upd_valid;
    assign set_idx = SET_W'(upd_addr % ADDR_W'(NUM_SETS));

    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_row
            assign row_vld[g] = vld_q[set_idx][g];
            assign row_tag[g] = tag_q[set_idx][g];
            assign row_use[g] = use_q[set_idx][g];
            assign row_ctr[g] = ctr_q[set_idx][g];
        end
    endgenerate

    bhb_lookup #(
        .NUM_WAYS   (NUM_WAYS),
        .USE_STATES (USE_STATES),
        .ADDR_W     (ADDR_W)
    ) u_lookup (
        .clk        (clk),
        .rst        (rst),
        .look_addr  (upd_addr),
        .row_vld    (row_vld),
        .row_tag    (row_tag),
        .row_use    (row_use),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    always_comb begin
        cur_ctr  = row_ctr[hit_way];
        pred_dir = hit && (cur_ctr >= CTR_W'(HALF));
        tgt_way  = hit ? hit_way : victim_way;
        if (hit)
            new_ctr = CTR_W'(dir_step(int'(cur_ctr), upd_taken, CTR_MAX));
        else
            new_ctr = CTR_W'(HALF - 1) + CTR_W'(upd_taken);
        evt.hit   = access && hit;
        evt.miss  = access && !hit;
        evt.right = access && hit && (pred_dir == upd_taken);
        evt.wrong = access && hit && (pred_dir != upd_taken);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                    tag_q[s][w] <= '0;
                    ctr_q[s][w] <= '0;
                    use_q[s][w] <= '0;
                end
            end
        end else if (access) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == tgt_way) begin
                    vld_q[set_idx][w] <= 1'b1;
                    tag_q[set_idx][w] <= upd_addr;
                    ctr_q[set_idx][w] <= new_ctr;
                    use_q[set_idx][w] <= USE_W'(USE_MAX);
                end else if (row_use[w] != '0) begin
                    use_q[set_idx][w] <= row_use[w] - USE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_pred  <= 1'b0;
        end else begin
            resp_valid <= access;
            resp_hit   <= access && hit;
            resp_pred  <= access && pred_dir;
        end
    end

    logic [3:0]             evt_vec;
    logic [3:0][STAT_W-1:0] cnt_vec;
    assign evt_vec = {evt.hit, evt.miss, evt.right, evt.wrong};

    generate
        for (g = 0; g < 4; g++) begin : g_stat
            bhb_satcnt #(.STAT_W(STAT_W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (evt_vec[g]),
                .count (cnt_vec[g])
            );
        end
    endgenerate

    assign hit_count   = cnt_vec[3];
    assign miss_count  = cnt_vec[2];
    assign right_count = cnt_vec[1];
    assign wrong_count = cnt_vec[0];

    AST_RESP_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(en && upd_valid)); // R9
    AST_MISS_NO_PRED: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> !resp_pred); // R4
    AST_MISS_NO_SCORE: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> ($stable(right_count) && $stable(wrong_count))); // R8
    AST_SCORE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (evt.right || evt.wrong) |-> evt.hit); // R8

endmodule

// File: tb/bhb_table_bench.sv
module bhb_table_bench;

    localparam int CLK_PERIOD = 10;
    localparam int B_MAX      = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic        a_en = 1'b0, a_valid = 1'b0, a_taken = 1'b0;
    logic [31:0] a_addr = '0;
    logic        a_rv, a_rh, a_rp;
    logic [31:0] a_hc, a_mc, a_rc, a_wc;

    logic        b_en = 1'b0, b_valid = 1'b0, b_taken = 1'b0;
    logic [15:0] b_addr = '0;
    logic        b_rv, b_rh, b_rp;
    logic [3:0]  b_hc, b_mc, b_rc, b_wc;

    int checks = 0, failures = 0;
    int ea_h = 0, ea_m = 0, ea_r = 0, ea_w = 0;
    int eb_h = 0, eb_m = 0, eb_r = 0, eb_w = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bhb_table u_bhb_table (
        .clk(clk), .rst(rst), .en(a_en), .upd_valid(a_valid), .upd_addr(a_addr),
        .upd_taken(a_taken), .resp_valid(a_rv), .resp_hit(a_rh), .resp_pred(a_rp),
        .hit_count(a_hc), .miss_count(a_mc), .right_count(a_rc), .wrong_count(a_wc)
    );

    bhb_table #(
        .NUM_SETS(8), .NUM_WAYS(2), .PRED_STATES(4), .USE_STATES(3),
        .ADDR_W(16), .STAT_W(4)
    ) u_bhb_table_wide (
        .clk(clk), .rst(rst), .en(b_en), .upd_valid(b_valid), .upd_addr(b_addr),
        .upd_taken(b_taken), .resp_valid(b_rv), .resp_hit(b_rh), .resp_pred(b_rp),
        .hit_count(b_hc), .miss_count(b_mc), .right_count(b_rc), .wrong_count(b_wc)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > B_MAX) ? B_MAX : v;
    endfunction

    // One update on the default instance, then check the response and counts.
    task automatic run_a(input logic [31:0] addr, input bit tk, input bit en, input bit vld,
                         input bit eh, input bit ep, input string req);
        @(negedge clk);
        a_en = en; a_valid = vld; a_addr = addr; a_taken = tk;
        @(negedge clk);
        a_valid = 1'b0; a_en = 1'b1;
        if (en && vld) begin
            if (eh) begin
                ea_h++;
                if (ep == tk) ea_r++; else ea_w++;
            end else ea_m++;
            chk(req, "resp_valid", a_rv, 1);
            chk(req, "resp_hit", a_rh, eh);
            chk(req, "resp_pred", a_rp, eh ? ep : 1'b0);
        end else begin
            chk(req, "resp_valid idle", a_rv, 0);
        end
        chk(req, "hit_count", a_hc, ea_h);
        chk(req, "miss_count", a_mc, ea_m);
        chk(req, "right_count", a_rc, ea_r);
        chk(req, "wrong_count", a_wc, ea_w);
    endtask

    // One update on the two-way instance with 4-bit saturating counts.
    task automatic run_b(input logic [15:0] addr, input bit tk, input bit eh, input bit ep,
                         input string req);
        @(negedge clk);
        b_en = 1'b1; b_valid = 1'b1; b_addr = addr; b_taken = tk;
        @(negedge clk);
        b_valid = 1'b0;
        if (eh) begin
            eb_h = sat(eb_h + 1);
            if (ep == tk) eb_r = sat(eb_r + 1); else eb_w = sat(eb_w + 1);
        end else eb_m = sat(eb_m + 1);
        chk(req, "b resp_valid", b_rv, 1);
        chk(req, "b resp_hit", b_rh, eh);
        chk(req, "b resp_pred", b_rp, eh ? ep : 1'b0);
        chk(req, "b hit_count", b_hc, eb_h);
        chk(req, "b miss_count", b_mc, eb_m);
        chk(req, "b right_count", b_rc, eb_r);
        chk(req, "b wrong_count", b_wc, eb_w);
    endtask

    task automatic t_reset;
        chk("R1", "resp_valid", a_rv, 0);
        chk("R1", "hit_count", a_hc, 0);
        chk("R1", "miss_count", a_mc, 0);
        chk("R1", "right_count", a_rc, 0);
        chk("R1", "wrong_count", a_wc, 0);
        chk("R1", "b miss_count", b_mc, 0);
        run_a(32'h0, 1'b0, 1, 1, 0, 0, "R1 addr0");
    endtask

    task automatic t_learn;
        run_a(32'h100, 1, 1, 1, 0, 0, "R3 seed taken");
        run_a(32'h100, 1, 1, 1, 1, 1, "R4 R3 predicts taken");
        run_a(32'h100, 0, 1, 1, 1, 1, "R5 wrong then down");
        run_a(32'h100, 0, 1, 1, 1, 0, "R5 at zero");
        run_a(32'h100, 0, 1, 1, 1, 0, "R5 hold at zero");
        run_a(32'h100, 1, 1, 1, 1, 0, "R8 wrong scored");
        run_a(32'h100, 1, 1, 1, 1, 1, "R5 up again");
        run_a(32'h204, 0, 1, 1, 0, 0, "R3 seed not taken");
        run_a(32'h204, 1, 1, 1, 1, 0, "R3 predicts not taken");
    endtask

    task automatic t_alias;
        run_a(32'h305, 1, 1, 1, 0, 0, "R2 first in set 5");
        run_a(32'h345, 1, 1, 1, 0, 0, "R2 alias misses");
        run_a(32'h305, 1, 1, 1, 0, 0, "R7 single way evicted");
        run_a(32'h306, 1, 1, 1, 0, 0, "R2 neighbour set");
        run_a(32'h305, 1, 1, 1, 1, 1, "R2 own set kept");
    endtask

    task automatic t_enable;
        run_a(32'h3A0, 1, 0, 1, 0, 0, "R9 enable low");
        run_a(32'h3A0, 1, 1, 0, 0, 0, "R9 valid low");
        run_a(32'h3A0, 1, 1, 1, 0, 0, "R9 nothing allocated");
    endtask

    // Set 3 of the two-way instance: usage decay drives victim choice.
    task automatic t_victim;
        run_b(16'h03, 1, 0, 0, "R7 A to way1");
        run_b(16'h0B, 1, 0, 0, "R7 B to way0");
        run_b(16'h13, 1, 0, 0, "R6 R7 C evicts A");
        run_b(16'h0B, 1, 1, 1, "R6 B hit");
        run_b(16'h03, 1, 0, 0, "R7 A evicts C");
        run_b(16'h0B, 1, 1, 1, "R6 B still held");
        run_b(16'h03, 1, 1, 1, "R6 A held");
        run_b(16'h13, 1, 0, 0, "R7 C evicts B");
        run_b(16'h03, 1, 1, 1, "R6 A survives");
    endtask

    // Four-state counter walk on set 5 and a not-taken seed on set 6.
    task automatic t_counter;
        run_b(16'h05, 1, 0, 0, "R3 seed 2");
        run_b(16'h05, 0, 1, 1, "R5 2 to 1");
        run_b(16'h05, 0, 1, 0, "R5 1 to 0");
        run_b(16'h05, 0, 1, 0, "R5 floor");
        run_b(16'h05, 1, 1, 0, "R5 0 to 1");
        run_b(16'h05, 1, 1, 0, "R5 1 to 2");
        run_b(16'h05, 1, 1, 1, "R5 2 to 3");
        run_b(16'h05, 1, 1, 1, "R5 ceiling");
        run_b(16'h05, 0, 1, 1, "R5 3 to 2");
        run_b(16'h05, 0, 1, 1, "R5 2 to 1");
        run_b(16'h05, 0, 1, 0, "R4 low half");
        run_b(16'h06, 0, 0, 0, "R3 seed 1");
        run_b(16'h06, 1, 1, 0, "R3 seed predicts not taken");
        run_b(16'h06, 1, 1, 1, "R4 high half");
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 12; k++)
            run_b(16'(16'h107 + 16'(k * 8)), 1, 0, 0, "R10 fill misses");
        chk("R10", "miss clamp", b_mc, B_MAX);
        chk("R10", "hit clamp", b_hc, B_MAX);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_learn();
        t_alias();
        t_enable();
        t_victim();
        t_counter();
        t_saturate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule